// File: doc/BRIEF.md
# Interrupt Controller Command and Initialization Port

This block is the front end of an eight-line programmable interrupt controller. It decodes byte reads and writes on a port with one address bit, which selects an even or an odd register address. Writes are sorted into four kinds: a start-of-initialization word, a mode command, an end-of-interrupt or rotation command that is passed on unchanged, and odd-address data. Odd-address data is routed by a small step machine. During initialization it fills the vector base and the optional later words. Outside initialization it loads the interrupt mask.

The configuration the block holds goes out as plain levels: the vector base, the auto-EOI and special fully nested flags, the read-back selector, the armed poll flag and the special-mask flag. The priority resolver next to it receives one-cycle strobes. One strobe means initialization restarted, so the resolver must reset its rotation base and rotate-on-auto-EOI state. Another means an EOI or rotation byte has arrived. Another means the mask changed and the request output must be evaluated again. A poll acknowledge strobe carries the line to clear from the request and in-service sets. The resolver returns its request and in-service sets and its current winner. The read path uses these for status reads and for poll reads.

Top module: `pic_cmd_port`

## Requirements
- R1: After a synchronous active-low reset, the mask, vector base, every flag and every strobe read 0, and initialization is not in progress.
- R2: An even-address write with data bit 4 set starts initialization. One cycle later `init_busy` and `init_stb` are 1, and `read_isr`, `nested_mode` and `auto_eoi` are 0. Data bit 1 of that word set means single mode, so no cascade word follows. Data bit 0 set means a mode word follows.
- R3: The first odd-address write after the start word sets `vec_base` to the written byte with its low three bits cleared.
- R4: After the vector base word, the next odd-address write is taken as a cascade word only in cascade mode. After that, one more odd-address write is taken as the mode word only if the start word requested one. When no further word is expected, `init_busy` returns to 0.
- R5: In the mode word, data bit 4 sets `nested_mode` and data bit 1 sets `auto_eoi`.
- R6: An even-address write with bit 4 clear and bit 3 set is a mode command. Bit 2 arms the poll. Bit 1 allows bit 0 to set `read_isr`, where 1 selects the in-service set and 0 selects the request set. Bit 6 allows bit 5 to set `special_mask`. A selector whose enable bit is 0 keeps its value.
- R7: An even-address write with bits 4 and 3 both clear raises `cmd_stb` for exactly one cycle, with the whole byte on `cmd_code`. No two of `init_stb`, `cmd_stb` and `imr_stb` are high in the same cycle.
- R8: An odd-address write outside initialization loads `imr` and raises `imr_stb` for one cycle.
- R9: A read with no poll armed returns `imr` at the odd address. At the even address it returns `isr_in` when `read_isr` is 1 and `irr_in` otherwise.
- R10: A read with the poll armed, at either address, returns 0x80 OR the winning line when `win_valid` is 1. In that case, one cycle later `ack_stb` is high with the line on `ack_line`. With no winner the read returns 0x07 and no acknowledge is raised. Either way the poll is disarmed.
- R11: A mode command that arms the poll, written in the same cycle as a poll read, leaves the poll armed. The read in that cycle still returns the poll result and raises the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Byte write this cycle |
| rd_en | input | 1 | Byte read this cycle |
| addr | input | 1 | Register address: 0 even, 1 odd |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, combinational, valid while `rd_en` is high |
| irr_in | input | 8 | Request set from the resolver |
| isr_in | input | 8 | In-service set from the resolver |
| win_valid | input | 1 | The resolver has a winning line |
| win_line | input | 3 | Winning line number |
| imr | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| auto_eoi | output | 1 | Automatic end of interrupt enabled |
| nested_mode | output | 1 | Special fully nested mode |
| read_isr | output | 1 | Status read selects the in-service set |
| poll_armed | output | 1 | The next read is a poll |
| special_mask | output | 1 | Special mask mode |
| init_busy | output | 1 | Initialization sequence in progress |
| init_stb | output | 1 | Initialization restarted; resolver clears its rotation state |
| cmd_stb | output | 1 | EOI or rotation byte available |
| cmd_code | output | 8 | EOI or rotation byte |
| imr_stb | output | 1 | Mask changed; re-evaluate the request output |
| ack_stb | output | 1 | Poll acknowledge for `ack_line` |
| ack_line | output | 3 | Line acknowledged by a poll |

## Verification
A poll read and a mode command that re-arms the poll can land in one cycle. The read path then answers from the old armed state, while the write sets up the next poll. The bench drives `rd_en` and `wr_en` together with byte 0x0C while a winner is present. It expects the poll value on `rdata` in that cycle, then an acknowledge and a still-armed poll one cycle later. Mode commands issued in the middle of an initialization sequence are also provoked. They must change the selectors without advancing the step machine.

// File: rtl/pic_cmd_pkg.sv
// Shared types for the command port: write kinds and initialization steps.
// Assumes an 8-bit command byte; the bit positions below are fixed by the
// command encoding and are read by the decoder and the register blocks.
package pic_cmd_pkg;

    typedef enum logic [2:0] {
        WK_NONE,   // no write this cycle
        WK_START,  // even address, start of initialization
        WK_MODE,   // even address, mode command
        WK_ROT,    // even address, EOI or rotation command
        WK_MASK,   // odd address, mask load
        WK_INIT    // odd address, initialization word
    } wkind_t;

    typedef enum logic [1:0] {
        STEP_IDLE,
        STEP_BASE,
        STEP_CASC,
        STEP_MODE
    } step_t;

    localparam int B_START   = 4;
    localparam int B_MODE    = 3;
    localparam int B_POLL    = 2;
    localparam int B_RSEL_EN = 1;
    localparam int B_RSEL    = 0;
    localparam int B_SM_EN   = 6;
    localparam int B_SM      = 5;
    localparam int B_SINGLE  = 1;
    localparam int B_NEED4   = 0;
    localparam int B_NEST    = 4;
    localparam int B_AEOI    = 1;

endpackage

// File: rtl/pic_wr_decode.sv
// Sorts a write into its kind from the address, two command bits and
// whether initialization is in progress. Purely combinational.
module pic_wr_decode
    import pic_cmd_pkg::*;
(
    input  logic   wr_en,
    input  logic   addr,
    input  logic   start_bit,
    input  logic   mode_bit,
    input  logic   busy,
    output wkind_t kind
);

    // Classify the current write.
    always_comb begin
        kind = WK_NONE;
        if (wr_en) begin
            if (!addr) begin
                if (start_bit)     kind = WK_START;
                else if (mode_bit) kind = WK_MODE;
                else               kind = WK_ROT;
            end else begin
                kind = busy ? WK_INIT : WK_MASK;
            end
        end
    end

endmodule

// File: rtl/pic_init_seq.sv
// Initialization step machine: holds the vector base and the mode-word
// flags. Assumes at most one write per cycle, already classified.
module pic_init_seq
    import pic_cmd_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LINES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wkind_t        kind,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic [DW-1:0] vec_base,
    output logic          auto_eoi,
    output logic          nested_mode,
    output logic          init_stb
);

    localparam int            LW        = $clog2(LINES);
    localparam logic [DW-1:0] BASE_MASK = {DW{1'b1}} << LW;

    step_t step_q;
    logic  casc_q;
    logic  need_mode_q;

    // Advance the sequence and capture the initialization fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q      <= STEP_IDLE;
            casc_q      <= 1'b0;
            need_mode_q <= 1'b0;
            vec_base    <= '0;
            auto_eoi    <= 1'b0;
            nested_mode <= 1'b0;
            init_stb    <= 1'b0;
        end else begin
            init_stb <= 1'b0;
            if (kind == WK_START) begin
                step_q      <= STEP_BASE;
                casc_q      <= !wdata[B_SINGLE];
                need_mode_q <= wdata[B_NEED4];
                nested_mode <= 1'b0;
                auto_eoi    <= 1'b0;
                init_stb    <= 1'b1;
            end else if (kind == WK_INIT) begin
                case (step_q)
                    STEP_BASE: begin
                        vec_base <= wdata & BASE_MASK;
                        step_q   <= casc_q ? STEP_CASC
                                           : (need_mode_q ? STEP_MODE : STEP_IDLE);
                    end
                    STEP_CASC: step_q <= need_mode_q ? STEP_MODE : STEP_IDLE;
                    STEP_MODE: begin
                        nested_mode <= wdata[B_NEST];
                        auto_eoi    <= wdata[B_AEOI];
                        step_q      <= STEP_IDLE;
                    end
                    default: step_q <= STEP_IDLE;
                endcase
            end
        end
    end

    assign busy = (step_q != STEP_IDLE);

    p_start_enters_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        kind == WK_START |=> (step_q == STEP_BASE && init_stb && !nested_mode && !auto_eoi));

    p_mode_word_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_INIT && step_q == STEP_MODE) |=> !busy);

    p_mode_word_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_INIT && step_q == STEP_MODE)
        |=> (nested_mode == $past(wdata[B_NEST]) && auto_eoi == $past(wdata[B_AEOI])));

    p_base_stable_outside_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != WK_INIT) |=> $stable(vec_base));

endmodule

// File: rtl/pic_ocw_regs.sv
// Operation registers: mask, read selector, poll and special-mask flags,
// and the strobes sent to the priority resolver. Assumes one write and at
// most one read per cycle; a same-cycle poll re-arm wins over disarm.
module pic_ocw_regs
    import pic_cmd_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LINES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  wkind_t                   kind,
    input  logic [DW-1:0]            wdata,
    input  logic                     rd_en,
    input  logic                     win_valid,
    input  logic [$clog2(LINES)-1:0] win_line,
    output logic [DW-1:0]            imr,
    output logic                     read_isr,
    output logic                     poll_armed,
    output logic                     special_mask,
    output logic                     cmd_stb,
    output logic [DW-1:0]            cmd_code,
    output logic                     imr_stb,
    output logic                     ack_stb,
    output logic [$clog2(LINES)-1:0] ack_line
);

    logic rearm;
    assign rearm = (kind == WK_MODE) && wdata[B_POLL];

    // Update the selectors and the mask; issue one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr          <= '0;
            read_isr     <= 1'b0;
            special_mask <= 1'b0;
            cmd_stb      <= 1'b0;
            cmd_code     <= '0;
            imr_stb      <= 1'b0;
        end else begin
            cmd_stb <= 1'b0;
            imr_stb <= 1'b0;
            case (kind)
                WK_START: read_isr <= 1'b0;
                WK_MODE: begin
                    if (wdata[B_RSEL_EN]) read_isr     <= wdata[B_RSEL];
                    if (wdata[B_SM_EN])   special_mask <= wdata[B_SM];
                end
                WK_ROT: begin
                    cmd_stb  <= 1'b1;
                    cmd_code <= wdata;
                end
                WK_MASK: begin
                    imr     <= wdata;
                    imr_stb <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Arm, consume and acknowledge polls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_armed <= 1'b0;
            ack_stb    <= 1'b0;
            ack_line   <= '0;
        end else begin
            ack_stb <= 1'b0;
            if (rearm)                   poll_armed <= 1'b1;
            else if (rd_en && poll_armed) poll_armed <= 1'b0;
            if (rd_en && poll_armed && win_valid) begin
                ack_stb  <= 1'b1;
                ack_line <= win_line;
            end
        end
    end

    p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        kind == WK_MASK |=> (imr_stb && imr == $past(wdata)));

    p_poll_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_armed && !rearm) |=> !poll_armed);

    p_poll_rearm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> poll_armed);

    p_ack_needs_winner_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |-> $past(win_valid && rd_en));

endmodule

// File: rtl/pic_read_path.sv
// Read multiplexer: poll result when armed, else mask or status set.
// Combinational; the acknowledge side effect lives in pic_ocw_regs.
module pic_read_path #(
    parameter int DW    = 8,
    parameter int LINES = 8
) (
    input  logic                     addr,
    input  logic                     poll_armed,
    input  logic                     read_isr,
    input  logic [DW-1:0]            imr,
    input  logic [DW-1:0]            irr_in,
    input  logic [DW-1:0]            isr_in,
    input  logic                     win_valid,
    input  logic [$clog2(LINES)-1:0] win_line,
    output logic [DW-1:0]            rdata
);

    localparam int            LW        = $clog2(LINES);
    localparam logic [DW-1:0] POLL_NONE = DW'(LINES - 1);

    logic [DW-1:0] poll_val;
    assign poll_val = win_valid ? {1'b1, {(DW-1-LW){1'b0}}, win_line} : POLL_NONE;

    // Select the byte returned to the reader.
    always_comb begin
        if (poll_armed) rdata = poll_val;
        else if (addr)  rdata = imr;
        else            rdata = read_isr ? isr_in : irr_in;
    end

endmodule

// File: rtl/pic_cmd_port.sv
// Command and initialization port of an eight-line interrupt controller.
// Decodes writes, runs the initialization steps, holds the operation
// registers and serves status and poll reads. Assumes the priority
// resolver consumes the strobes and supplies the request, in-service and
// winner inputs.
module pic_cmd_port
    import pic_cmd_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LINES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic                     addr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata,
    input  logic [DW-1:0]            irr_in,
    input  logic [DW-1:0]            isr_in,
    input  logic                     win_valid,
    input  logic [$clog2(LINES)-1:0] win_line,
    output logic [DW-1:0]            imr,
    output logic [DW-1:0]            vec_base,
    output logic                     auto_eoi,
    output logic                     nested_mode,
    output logic                     read_isr,
    output logic                     poll_armed,
    output logic                     special_mask,
    output logic                     init_busy,
    output logic                     init_stb,
    output logic                     cmd_stb,
    output logic [DW-1:0]            cmd_code,
    output logic                     imr_stb,
    output logic                     ack_stb,
    output logic [$clog2(LINES)-1:0] ack_line
);

    wkind_t kind;

    pic_wr_decode u_dec (
        .wr_en     (wr_en),
        .addr      (addr),
        .start_bit (wdata[B_START]),
        .mode_bit  (wdata[B_MODE]),
        .busy      (init_busy),
        .kind      (kind)
    );

    pic_init_seq #(.DW(DW), .LINES(LINES)) u_init (
        .clk         (clk),
        .rst_n       (rst_n),
        .kind        (kind),
        .wdata       (wdata),
        .busy        (init_busy),
        .vec_base    (vec_base),
        .auto_eoi    (auto_eoi),
        .nested_mode (nested_mode),
        .init_stb    (init_stb)
    );

    pic_ocw_regs #(.DW(DW), .LINES(LINES)) u_ocw (
        .clk          (clk),
        .rst_n        (rst_n),
        .kind         (kind),
        .wdata        (wdata),
        .rd_en        (rd_en),
        .win_valid    (win_valid),
        .win_line     (win_line),
        .imr          (imr),
        .read_isr     (read_isr),
        .poll_armed   (poll_armed),
        .special_mask (special_mask),
        .cmd_stb      (cmd_stb),
        .cmd_code     (cmd_code),
        .imr_stb      (imr_stb),
        .ack_stb      (ack_stb),
        .ack_line     (ack_line)
    );

    pic_read_path #(.DW(DW), .LINES(LINES)) u_rd (
        .addr       (addr),
        .poll_armed (poll_armed),
        .read_isr   (read_isr),
        .imr        (imr),
        .irr_in     (irr_in),
        .isr_in     (isr_in),
        .win_valid  (win_valid),
        .win_line   (win_line),
        .rdata      (rdata)
    );

    p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({init_stb, cmd_stb, imr_stb}));

    p_busy_blocks_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && init_busy) |=> !imr_stb);

endmodule

// File: tb/pic_cmd_port_tb_top.sv
// Behavioural reference model of the command port, compared every cycle.
module pic_cmd_port_tb_top;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = 8'h00, irr_in = 8'h00, isr_in = 8'h00;
    logic       win_valid = 1'b0;
    logic [2:0] win_line = 3'd0;
    logic [7:0] rdata, imr, vec_base, cmd_code;
    logic       auto_eoi, nested_mode, read_isr, poll_armed, special_mask;
    logic       init_busy, init_stb, cmd_stb, imr_stb, ack_stb;
    logic [2:0] ack_line;

    int checks = 0;
    int fails  = 0;

    // model state
    logic [7:0] m_imr = 0, m_vb = 0, m_code = 0;
    logic       m_aeoi = 0, m_nest = 0, m_rsel = 0, m_poll = 0, m_smask = 0;
    int         m_step = 0;
    logic       m_casc = 0, m_need4 = 0;
    logic       m_istb = 0, m_cstb = 0, m_mstb = 0, m_astb = 0;
    logic [2:0] m_aline = 0;
    string      over_tag = "";
    string      poll_tag = "R6";

    always #(CLK_P/2) clk = ~clk;

    pic_cmd_port dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irr_in(irr_in), .isr_in(isr_in),
        .win_valid(win_valid), .win_line(win_line), .imr(imr),
        .vec_base(vec_base), .auto_eoi(auto_eoi), .nested_mode(nested_mode),
        .read_isr(read_isr), .poll_armed(poll_armed),
        .special_mask(special_mask), .init_busy(init_busy),
        .init_stb(init_stb), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
        .imr_stb(imr_stb), .ack_stb(ack_stb), .ack_line(ack_line)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        string r;
        r = (over_tag != "") ? over_tag : req;
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", r, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R8", "imr", imr, m_imr);
        chk("R3", "vec_base", vec_base, m_vb);
        chk("R5", "auto_eoi", auto_eoi, m_aeoi);
        chk("R5", "nested_mode", nested_mode, m_nest);
        chk("R6", "read_isr", read_isr, m_rsel);
        chk(poll_tag, "poll_armed", poll_armed, m_poll);
        chk("R6", "special_mask", special_mask, m_smask);
        chk("R4", "init_busy", init_busy, m_step != 0);
        chk("R2", "init_stb", init_stb, m_istb);
        chk("R7", "cmd_stb", cmd_stb, m_cstb);
        if (m_cstb) chk("R7", "cmd_code", cmd_code, m_code);
        chk("R8", "imr_stb", imr_stb, m_mstb);
        chk("R10", "ack_stb", ack_stb, m_astb);
        if (m_astb) chk("R10", "ack_line", ack_line, m_aline);
    endtask

    // One clock: drive, check read data, step the model, compare state.
    task automatic cyc(input bit w, input bit r, input bit a, input logic [7:0] d);
        logic [7:0] erd;
        logic       rearm;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        #1;
        rearm = w && !a && !d[4] && d[3] && d[2];
        poll_tag = (r && m_poll && rearm) ? "R11" : ((r && m_poll) ? "R10" : "R6");
        if (r) begin
            if (m_poll) erd = win_valid ? (8'h80 | {5'd0, win_line}) : 8'h07;
            else if (a) erd = m_imr;
            else        erd = m_rsel ? isr_in : irr_in;
            chk(m_poll ? poll_tag : "R9", "rdata", rdata, erd);
        end
        m_istb = 0; m_cstb = 0; m_mstb = 0; m_astb = 0;
        if (r && m_poll && win_valid) begin m_astb = 1; m_aline = win_line; end
        if (r && m_poll) m_poll = 0;
        if (w) begin
            if (!a && d[4]) begin
                m_step = 2; m_casc = !d[1]; m_need4 = d[0];
                m_rsel = 0; m_nest = 0; m_aeoi = 0; m_istb = 1;
            end else if (!a && d[3]) begin
                if (d[2]) m_poll = 1;
                if (d[1]) m_rsel = d[0];
                if (d[6]) m_smask = d[5];
            end else if (!a) begin
                m_cstb = 1; m_code = d;
            end else if (m_step == 0) begin
                m_imr = d; m_mstb = 1;
            end else if (m_step == 2) begin
                m_vb = d & 8'hF8;
                m_step = m_casc ? 3 : (m_need4 ? 4 : 0);
            end else if (m_step == 3) begin
                m_step = m_need4 ? 4 : 0;
            end else begin
                m_nest = d[4]; m_aeoi = d[1]; m_step = 0;
            end
        end
        @(posedge clk);
        #1;
        compare_all();
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        over_tag = "R1"; compare_all(); over_tag = "";

        // R9: status reads
        irr_in = 8'h5A; isr_in = 8'hA1;
        cyc(0, 1, 0, 8'h00);
        cyc(0, 1, 1, 8'h00);
        // R8: mask load
        cyc(1, 0, 1, 8'hC3);
        cyc(0, 1, 1, 8'h00);

        // R2/R3/R4/R5: cascade with mode word
        cyc(1, 0, 0, 8'h11);
        cyc(1, 0, 1, 8'h47);
        cyc(0, 1, 1, 8'h00);          // mask read while initializing
        cyc(1, 0, 1, 8'h04);
        cyc(1, 0, 1, 8'h12);
        // single mode with mode word: clears nested flag at start
        cyc(1, 0, 0, 8'h13);
        cyc(1, 0, 1, 8'h28);
        cyc(1, 0, 1, 8'h02);
        // single mode, no mode word, then mask goes to imr
        cyc(1, 0, 0, 8'h12);
        cyc(1, 0, 1, 8'hFF);
        cyc(1, 0, 1, 8'h3C);

        // R6: read selector and special mask
        cyc(1, 0, 0, 8'h0B);
        cyc(0, 1, 0, 8'h00);
        cyc(1, 0, 0, 8'h08);
        cyc(0, 1, 0, 8'h00);
        cyc(1, 0, 0, 8'h0A);
        cyc(0, 1, 0, 8'h00);
        cyc(1, 0, 0, 8'h68);
        cyc(1, 0, 0, 8'h28);
        cyc(1, 0, 0, 8'h48);

        // R7: rotation commands
        cyc(1, 0, 0, 8'h20);
        cyc(1, 0, 0, 8'hE5);
        cyc(0, 0, 0, 8'h00);

        // R10: poll with and without a winner
        win_valid = 1; win_line = 3'd5;
        cyc(1, 0, 0, 8'h0C);
        cyc(0, 1, 1, 8'h00);
        cyc(0, 0, 0, 8'h00);
        win_valid = 0;
        cyc(1, 0, 0, 8'h0C);
        cyc(0, 1, 0, 8'h00);
        cyc(0, 1, 0, 8'h00);

        // R11: poll read and re-arm in one cycle
        win_valid = 1; win_line = 3'd2;
        cyc(1, 0, 0, 8'h0C);
        cyc(1, 1, 0, 8'h0C);
        cyc(0, 1, 0, 8'h00);
        cyc(0, 1, 0, 8'h00);

        // mode command in the middle of initialization
        cyc(1, 0, 0, 8'h11);
        cyc(1, 0, 0, 8'h0B);
        cyc(1, 0, 1, 8'h90);
        cyc(1, 0, 0, 8'h20);
        cyc(1, 0, 1, 8'h00);
        cyc(1, 0, 1, 8'h10);

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            irr_in = 8'($urandom); isr_in = 8'($urandom);
            win_valid = 1'($urandom); win_line = 3'($urandom);
            cyc(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule